// File: doc/BRIEF.md
# Multi-Bank Interrupt Aggregator

This block gathers twenty-four single-bit event inputs from power-management sources into three sticky status banks of eight bits, and raises a single active-high interrupt request towards a host processor. Each bank has two mask registers: a capture mask, which decides whether an event edge may set its status bit at all, and a line mask, which decides whether a set status bit may drive the interrupt request. A bit set to 1 in either mask disables that source at that layer.

The host reaches the block through a byte-wide register port that supports sequential bursts. A beat marked as first loads its address; every further beat of the burst works on the address one above the previous beat. A typical service routine reads the three status banks in one three-beat burst from address 0 and then acknowledges everything with one byte write of any value to any status address, which empties all three banks at once. Initialisation writes 0xFF bursts to the line masks, then to the capture masks, then to the status banks.

The port carries no back-pressure: every beat presented with `acc_valid` is accepted in that cycle, and the read data comes back on the following cycle with `rd_valid`. The serial bus front end and the event sources sit outside the block.

Top module: `pmic_irq_agg`

## Requirements
- R1: After reset all six mask registers read 0xFF, all status bits read 0, `irq_o` is 0 and `rd_valid` is 0.
- R2: A status bit sets on the cycle in which its event input is sampled high after being sampled low, provided its capture-mask bit is 0; it stays set after the input falls, and an input held high sets it only once.
- R3: While a capture-mask bit is 1, edges on that source leave its status bit at 0.
- R4: `irq_o` is the OR over all sources of (status AND NOT line-mask), registered one cycle; a set status bit under a line-mask bit of 1 stays readable but does not raise `irq_o`.
- R5: A write beat of any data value to address 0, 1 or 2 clears all twenty-four status bits on that clock edge.
- R6: When an event edge and a status-clearing write occur in the same cycle, the status bit of that event is set after the edge while all other status bits are cleared.
- R7: Sources 12 and 23 (bank B bit 4 and bank C bit 7) are reserved: their status bits never set and read 0.
- R8: A beat with `acc_first`=1 uses `acc_addr`; a beat with `acc_first`=0 uses the previous beat's address plus one, for reads and writes alike.
- R9: Address map: status banks A, B, C at 0, 1, 2 (source n lives in bank n/8, bit n%8); line masks A, B, C at 3, 4, 5; capture masks A, B, C at 6, 7, 8. Reads of addresses 9 to 15 return 0 and writes there change nothing.
- R10: `rd_valid` is 1 exactly on the cycle after a read beat, with `rd_data` holding the addressed byte as it was when the beat was accepted; after a write beat `rd_valid` is 0.
- R11: A write beat to a mask address stores the written byte, which reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 24 | Event inputs, bit n is source n |
| acc_valid | input | 1 | Register beat present this cycle |
| acc_first | input | 1 | Beat starts a burst and uses acc_addr |
| acc_addr | input | 4 | Start address of a burst |
| acc_write | input | 1 | 1 for a write beat, 0 for a read beat |
| acc_wdata | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data present |
| rd_data | output | 8 | Read data byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach from the ports is an event edge landing in exactly the cycle a clearing write is accepted, since it needs both the event input and the register port aligned to the same clock edge. The bench drives the rising event bit and the write beat at the same falling edge, after first setting an unrelated status bit in another bank, so that a single burst read afterwards shows both the surviving new bit and the cleared old one. A held-high input across a clear is also provoked to show that a level alone never re-arms capture.

// File: rtl/pmic_irq_pkg.sv
package pmic_irq_pkg;

  localparam int BANK_BITS  = 8;
  localparam int BANK_COUNT = 3;
  localparam int PORT_ADDR  = 4;

  // Register groups, laid out in this order from address 0 upward.
  typedef enum logic [1:0] {
    GRP_STAT = 2'd0,
    GRP_LINE = 2'd1,
    GRP_CAPT = 2'd2,
    GRP_NONE = 2'd3
  } reg_grp_e;

endpackage

// File: rtl/pmic_irq_capture.sv
// One status bank: edge detection on its event inputs and sticky storage.
module pmic_irq_capture #(
  parameter int              BANK_W = pmic_irq_pkg::BANK_BITS,
  parameter logic [BANK_W-1:0] RSVD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] evt,
  input  logic [BANK_W-1:0] capt_mask,
  input  logic              wipe,
  output logic [BANK_W-1:0] stat,
  output logic [BANK_W-1:0] set_hit
);

  logic [BANK_W-1:0] evt_q;
  logic [BANK_W-1:0] rise;

  assign rise    = evt & ~evt_q;
  assign set_hit = rise & ~capt_mask & ~RSVD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      stat  <= '0;
    end else begin
      evt_q <= evt;
      // A new edge outranks a clear arriving in the same cycle.
      stat  <= (wipe ? '0 : stat) | set_hit;
    end
  end

endmodule

// File: rtl/pmic_irq_regport.sv
// Byte register port: burst address pointer, decode, mask storage, readback.
module pmic_irq_regport
  import pmic_irq_pkg::*;
#(
  parameter int NUM_BANKS = BANK_COUNT,
  parameter int BANK_W    = BANK_BITS,
  parameter int ADDR_W    = PORT_ADDR,
  localparam int SRC_W    = NUM_BANKS * BANK_W,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_first,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [BANK_W-1:0] acc_wdata,
  input  logic [SRC_W-1:0]  stat_flat,
  output logic [SRC_W-1:0]  line_flat,
  output logic [SRC_W-1:0]  capt_flat,
  output logic              wipe,
  output logic              rd_valid,
  output logic [BANK_W-1:0] rd_data
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] addr_eff;
  reg_grp_e          grp;
  logic [IDX_W-1:0]  idx;
  logic [BANK_W-1:0] rd_c;
  logic [BANK_W-1:0] line_q [NUM_BANKS];
  logic [BANK_W-1:0] capt_q [NUM_BANKS];

  assign addr_eff = acc_first ? acc_addr : ptr_q;

  always_comb begin
    grp = GRP_NONE;
    idx = '0;
    if (int'(addr_eff) < NUM_BANKS) begin
      grp = GRP_STAT;
      idx = IDX_W'(addr_eff);
    end else if (int'(addr_eff) < 2 * NUM_BANKS) begin
      grp = GRP_LINE;
      idx = IDX_W'(addr_eff - ADDR_W'(NUM_BANKS));
    end else if (int'(addr_eff) < 3 * NUM_BANKS) begin
      grp = GRP_CAPT;
      idx = IDX_W'(addr_eff - ADDR_W'(2 * NUM_BANKS));
    end
  end

  assign wipe = acc_valid && acc_write && (grp == GRP_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (acc_valid) begin
      ptr_q <= addr_eff + ADDR_W'(1);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
    logic sel_b;
    assign sel_b = acc_valid && acc_write && (idx == IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[b] <= '1;
        capt_q[b] <= '1;
      end else begin
        if (sel_b && grp == GRP_LINE) line_q[b] <= acc_wdata;
        if (sel_b && grp == GRP_CAPT) capt_q[b] <= acc_wdata;
      end
    end

    assign line_flat[b*BANK_W +: BANK_W] = line_q[b];
    assign capt_flat[b*BANK_W +: BANK_W] = capt_q[b];
  end

  always_comb begin
    rd_c = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (idx == IDX_W'(b)) begin
        case (grp)
          GRP_STAT: rd_c = stat_flat[b*BANK_W +: BANK_W];
          GRP_LINE: rd_c = line_q[b];
          GRP_CAPT: rd_c = capt_q[b];
          default:  rd_c = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= rd_c;
    end
  end

endmodule

// File: rtl/pmic_irq_line.sv
// Combines unmasked status into the registered interrupt request.
module pmic_irq_line #(
  parameter int SRC_W = pmic_irq_pkg::BANK_COUNT * pmic_irq_pkg::BANK_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] stat,
  input  logic [SRC_W-1:0] line_mask,
  output logic             irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat & ~line_mask);
  end

endmodule

// File: rtl/pmic_irq_agg.sv
module pmic_irq_agg
  import pmic_irq_pkg::*;
#(
  parameter int NUM_BANKS = BANK_COUNT,
  parameter int BANK_W    = BANK_BITS,
  parameter int ADDR_W    = PORT_ADDR,
  parameter logic [NUM_BANKS*BANK_W-1:0] RSVD_MAP = 24'h80_1000,
  localparam int SRC_W    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic              acc_valid,
  input  logic              acc_first,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [BANK_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [BANK_W-1:0] rd_data,
  output logic              irq_o
);

  logic [SRC_W-1:0] stat_w;
  logic [SRC_W-1:0] set_w;
  logic [SRC_W-1:0] line_w;
  logic [SRC_W-1:0] capt_w;
  logic             wipe_w;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pmic_irq_capture #(
      .BANK_W (BANK_W),
      .RSVD   (RSVD_MAP[b*BANK_W +: BANK_W])
    ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt_i[b*BANK_W +: BANK_W]),
      .capt_mask (capt_w[b*BANK_W +: BANK_W]),
      .wipe      (wipe_w),
      .stat      (stat_w[b*BANK_W +: BANK_W]),
      .set_hit   (set_w[b*BANK_W +: BANK_W])
    );
  end

  pmic_irq_regport #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_first (acc_first),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .acc_wdata (acc_wdata),
    .stat_flat (stat_w),
    .line_flat (line_w),
    .capt_flat (capt_w),
    .wipe      (wipe_w),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  pmic_irq_line #(.SRC_W(SRC_W)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat      (stat_w),
    .line_mask (line_w),
    .irq       (irq_o)
  );

endmodule

// File: rtl/pmic_irq_chk.sv
module pmic_irq_chk #(
  parameter int SRC_W = 24,
  parameter logic [SRC_W-1:0] RSVD_MAP = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             rd_valid,
  input logic             irq_o,
  input logic [SRC_W-1:0] stat,
  input logic [SRC_W-1:0] set_vec,
  input logic [SRC_W-1:0] line_mask,
  input logic [SRC_W-1:0] capt_mask,
  input logic             wipe
);

  // R7: reserved sources stay clear
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & RSVD_MAP) == '0);

  // R4: unmasked status drives the request one cycle later
  a_r4_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~line_mask)) |=> irq_o);
  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & ~line_mask)) |=> !irq_o);

  // R10: read data strobe follows read beats only
  a_r10_rd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

  // R3: fully masked capture keeps an empty status empty
  a_r3_capture_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0 && capt_mask == '1) |=> stat == '0);

  // R2: set bits are sticky without a clear
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && stat != '0) |=> ((stat & $past(stat)) == $past(stat)));

  // R5 and R6: a clear leaves exactly the new edges
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> stat == $past(set_vec));

endmodule

bind pmic_irq_agg pmic_irq_chk #(
  .SRC_W    (SRC_W),
  .RSVD_MAP (RSVD_MAP)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .rd_valid  (rd_valid),
  .irq_o     (irq_o),
  .stat      (stat_w),
  .set_vec   (set_w),
  .line_mask (line_w),
  .capt_mask (capt_w),
  .wipe      (wipe_w)
);

// File: tb/pmic_irq_agg_tb.sv
module pmic_irq_agg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] evt = '0;
  logic        acc_valid = 1'b0;
  logic        acc_first = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pmic_irq_agg dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .acc_valid (acc_valid),
    .acc_first (acc_first),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .acc_wdata (acc_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .irq_o     (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [3:0] a, input bit first, input logic [7:0] d);
    acc_valid = 1'b1; acc_first = first; acc_addr = a;
    acc_write = 1'b1; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_first = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input bit first, output logic [7:0] d, output logic v);
    acc_valid = 1'b1; acc_first = first; acc_addr = a; acc_write = 1'b0;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    acc_valid = 1'b0; acc_first = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input bit first, input logic [7:0] exp);
    logic [7:0] d; logic v;
    rd(a, first, d, v);
    chk({tag, " rd_valid"}, 32'(v), 32'd1);
    chk(tag, 32'(d), 32'(exp));
  endtask

  task automatic pulse(input logic [23:0] bits);
    evt = evt | bits;
    @(negedge clk);
    evt = evt & ~bits;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", 32'(irq_o), 0);
    chk("R1 rd_valid after reset", 32'(rd_valid), 0);
    rd_chk("R1 R9 status A", 4'd0, 1'b1, 8'h00);
    for (int i = 1; i < 3; i++) rd_chk("R1 R8 status burst", 4'(i), 1'b0, 8'h00);
    for (int i = 3; i < 9; i++) rd_chk("R1 R8 mask burst", 4'(i), 1'b0, 8'hFF);
    rd_chk("R9 unmapped 9", 4'd9, 1'b0, 8'h00);
    rd_chk("R9 unmapped 15", 4'd15, 1'b1, 8'h00);
  endtask

  task automatic t_init;
    for (int i = 0; i < 3; i++) wr(4'(3 + i), i == 0, 8'hFF);
    for (int i = 0; i < 3; i++) wr(4'(6 + i), i == 0, 8'hFF);
    for (int i = 0; i < 3; i++) wr(4'(i), i == 0, 8'hFF);
    rd_chk("R11 capture mask A after init", 4'd6, 1'b1, 8'hFF);
  endtask

  task automatic t_capture;
    wr(4'd6, 1'b1, 8'h00);
    pulse(24'h00_0002);
    rd_chk("R2 sticky bit 1", 4'd0, 1'b1, 8'h02);
    chk("R4 line-masked no irq", 32'(irq_o), 0);
    // held level: one capture, no re-arm after clear
    evt[2] = 1'b1;
    @(negedge clk);
    wr(4'd0, 1'b1, 8'h00);
    @(negedge clk);
    rd_chk("R2 held level no re-set", 4'd0, 1'b1, 8'h00);
    evt[2] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_blocked;
    pulse(24'h00_0200);
    rd_chk("R3 masked bank B", 4'd1, 1'b1, 8'h00);
    wr(4'd7, 1'b1, 8'h00);
    wr(4'd8, 1'b0, 8'h00);
    pulse(24'h81_1200);
    rd_chk("R7 bank B reserved bit 4", 4'd1, 1'b1, 8'h02);
    rd_chk("R7 bank C reserved bit 7", 4'd2, 1'b0, 8'h01);
  endtask

  task automatic t_irq_clear;
    wr(4'd3, 1'b1, 8'h00);
    chk("R4 A clear no irq", 32'(irq_o), 0);
    wr(4'd5, 1'b1, 8'hFE);
    @(negedge clk);
    chk("R4 irq from bank C", 32'(irq_o), 1);
    wr(4'd2, 1'b1, 8'h5A);
    rd_chk("R5 clear A", 4'd0, 1'b1, 8'h00);
    rd_chk("R5 clear B", 4'd1, 1'b0, 8'h00);
    rd_chk("R5 clear C", 4'd2, 1'b0, 8'h00);
    chk("R4 irq drops after clear", 32'(irq_o), 0);
    wr(4'd5, 1'b1, 8'hFF);
  endtask

  task automatic t_race;
    wr(4'd3, 1'b1, 8'hFD);
    pulse(24'h00_0200);
    rd_chk("R6 setup bank B", 4'd1, 1'b1, 8'h02);
    chk("R6 setup irq low", 32'(irq_o), 0);
    evt[1] = 1'b1;
    wr(4'd1, 1'b1, 8'h33);
    evt[1] = 1'b0;
    @(negedge clk);
    chk("R6 irq from surviving bit", 32'(irq_o), 1);
    rd_chk("R6 new edge kept", 4'd0, 1'b1, 8'h02);
    rd_chk("R6 old bit cleared", 4'd1, 1'b0, 8'h00);
    wr(4'd0, 1'b1, 8'h00);
    wr(4'd3, 1'b1, 8'hFF);
  endtask

  task automatic t_burst_write;
    logic [7:0] d; logic v;
    wr(4'd3, 1'b1, 8'h11);
    wr(4'd0, 1'b0, 8'h22);
    wr(4'd0, 1'b0, 8'h33);
    chk("R10 no strobe after write", 32'(rd_valid), 0);
    wr(4'd12, 1'b1, 8'h00);
    wr(4'd9, 1'b1, 8'h00);
    rd_chk("R11 R8 line A", 4'd3, 1'b1, 8'h11);
    rd_chk("R11 R8 line B", 4'd0, 1'b0, 8'h22);
    rd_chk("R11 R8 line C", 4'd0, 1'b0, 8'h33);
    rd_chk("R9 capture A untouched", 4'd6, 1'b0, 8'h00);
    rd(4'd0, 1'b1, d, v);
    @(negedge clk);
    chk("R10 strobe single cycle", 32'(rd_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init();
    t_capture();
    t_blocked();
    t_irq_clear();
    t_race();
    t_burst_write();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule